// File: doc/BRIEF.md
# Convolution Tap Sequencer with Padding Lane Mask

This control block steps through the kernel-width taps of an implicit-GEMM convolution for one tile of output positions. Each tile lane stands for one output position. The lanes cover consecutive output columns, and a run of columns may cross from one image into the next. For every tap the block issues a short series of commands to a tile memory over a valid/ready channel. On the first tap it asks for a full tile load. On every later tap it asks the memory to move the tile up by one lane, then to load a single new row into lane 0, and then to compute.

Every command carries a per-lane disable mask. For each lane the block works out the input column `w = q*stride - pad + s*dilation`. A lane whose `w` lies left of column 0 or at or beyond the image width falls in padding. The memory fills such a lane with zero and does not write its result back. The block splits lanes into columns with a wrapping column counter and keeps a running stride sum, so it needs no divider and only one multiply, which happens at start. Above the tap loop the block walks channel blocks, then output-channel blocks, then kernel rows. It pulses done after the last compute command is accepted.

The configuration inputs must stay stable while `busy` is high.

Top module: `conv_tap_sequencer`

## Requirements
- R1: After reset, `busy`, `cmd_valid` and `done` are all 0.
- R2: Lane m covers output column q = (cfg_q0 + m) mod cfg_qcols, which wraps into the next image at cfg_qcols, and its input column is w = q*cfg_stride - cfg_pad + s*cfg_dil.
- R3: Bit m of `cmd_mask` is 1 exactly when lane m's w is below 0 or at least cfg_width. It is 0 otherwise.
- R4: For tap s = 0 the commands are full load (`cmd_op` = 0) and then compute (`cmd_op` = 3).
- R5: For each tap s > 0 the commands are shift (`cmd_op` = 1), then row load into lane 0 (`cmd_op` = 2), then compute (`cmd_op` = 3).
- R6: The tap index s is the innermost loop (0 to cfg_taps-1). Above it come the channel block (`cmd_c`, 0 to cfg_cblk-1), then the output-channel block (`cmd_k`, 0 to cfg_kblk-1), then the kernel row (`cmd_r`, 0 to cfg_rtaps-1), which is outermost. Every command reports the current indices.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, the command fields and `cmd_valid` hold unchanged.
- R8: `done` is high for exactly one cycle, the cycle after the last compute command is accepted, and `busy` falls in that same cycle.
- R9: A `start` pulse while `busy` is 1 has no effect on the command sequence.
- R10: The first command becomes valid exactly LANES cycles after the clock edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| cfg_width | input | CW | Image width W in columns |
| cfg_qcols | input | CW | Output columns per image |
| cfg_q0 | input | CW | Output column of lane 0 |
| cfg_stride | input | FW | Horizontal stride |
| cfg_pad | input | FW | Left padding |
| cfg_dil | input | FW | Horizontal dilation |
| cfg_taps | input | FW | Kernel width S (at least 1) |
| cfg_rtaps | input | FW | Kernel height R (at least 1) |
| cfg_kblk | input | BW | Output-channel block count (at least 1) |
| cfg_cblk | input | BW | Input-channel block count (at least 1) |
| busy | output | 1 | Run in progress |
| cmd_valid | output | 1 | Command is offered |
| cmd_ready | input | 1 | Tile memory accepts the command |
| cmd_op | output | 2 | 0 full load, 1 shift, 2 row load, 3 compute |
| cmd_s | output | FW | Current tap index |
| cmd_r | output | FW | Current kernel row |
| cmd_k | output | BW | Current output-channel block |
| cmd_c | output | BW | Current channel block |
| cmd_mask | output | LANES | Per-lane disable (padding) mask |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The first pattern uses unit stride, pad and dilation, with a tile that starts mid-row and wraps into a second image. It shows that the left-padding lane of the later image is masked only at tap 0 and that the right-edge lane is masked only at the last tap. A second pattern uses stride and dilation of 2 with nested row, channel and output-channel blocks under a random ready. It separates the loop order and the running tap offset from a plain per-lane index. A single-tap run checks that no shift is ever issued. A case with padding wider than the image masks every lane. A start pulse sent mid-run must leave the sequence untouched.

// File: rtl/conv_tap_sequencer.sv
module conv_tap_sequencer #(
  parameter int LANES = 8,
  parameter int CW    = 8,
  parameter int FW    = 4,
  parameter int BW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    cfg_width,
  input  logic [CW-1:0]    cfg_qcols,
  input  logic [CW-1:0]    cfg_q0,
  input  logic [FW-1:0]    cfg_stride,
  input  logic [FW-1:0]    cfg_pad,
  input  logic [FW-1:0]    cfg_dil,
  input  logic [FW-1:0]    cfg_taps,
  input  logic [FW-1:0]    cfg_rtaps,
  input  logic [BW-1:0]    cfg_kblk,
  input  logic [BW-1:0]    cfg_cblk,
  output logic             busy,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [FW-1:0]    cmd_s,
  output logic [FW-1:0]    cmd_r,
  output logic [BW-1:0]    cmd_k,
  output logic [BW-1:0]    cmd_c,
  output logic [LANES-1:0] cmd_mask,
  output logic             done
);
  localparam int SW = CW + FW + 2;
  localparam int MW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [1:0] OP_FULL = 2'd0, OP_SHIFT = 2'd1, OP_ROW = 2'd2, OP_MAC = 2'd3;

  typedef enum logic [1:0] {IDLE, PREP, ISSUE} state_t;
  state_t state;

  logic [MW-1:0]        m_cnt;
  logic [CW-1:0]        q_cnt;
  logic signed [SW-1:0] qs_acc, s_off;
  logic signed [SW-1:0] base_q [LANES];
  logic [FW-1:0]        s_cnt, r_cnt;
  logic [BW-1:0]        k_cnt, c_cnt;
  logic [1:0]           op;
  logic                 done_q;

  wire accept   = (state == ISSUE) && cmd_ready;
  wire last_s   = (s_cnt == cfg_taps - 1'b1);
  wire last_c   = (c_cnt == cfg_cblk - 1'b1);
  wire last_k   = (k_cnt == cfg_kblk - 1'b1);
  wire last_r   = (r_cnt == cfg_rtaps - 1'b1);
  wire signed [SW-1:0] pad_s = $signed(SW'(cfg_pad));
  wire signed [SW-1:0] wid_s = $signed(SW'(cfg_width));

  assign busy      = (state != IDLE);
  assign cmd_valid = (state == ISSUE);
  assign cmd_op    = op;
  assign cmd_s     = s_cnt;
  assign cmd_r     = r_cnt;
  assign cmd_k     = k_cnt;
  assign cmd_c     = c_cnt;
  assign done      = done_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wire signed [SW-1:0] w_col = base_q[g] + s_off;
    assign cmd_mask[g] = w_col[SW-1] || (w_col >= wid_s);
  end

  always_ff @(posedge clk) begin
    if (state == PREP) base_q[m_cnt] <= qs_acc - pad_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      m_cnt  <= '0;
      q_cnt  <= '0;
      qs_acc <= '0;
      s_off  <= '0;
      s_cnt  <= '0;
      r_cnt  <= '0;
      k_cnt  <= '0;
      c_cnt  <= '0;
      op     <= OP_FULL;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        IDLE: if (start) begin
          state  <= PREP;
          m_cnt  <= '0;
          q_cnt  <= cfg_q0;
          qs_acc <= $signed(SW'(cfg_q0) * SW'(cfg_stride));
          s_off  <= '0;
          s_cnt  <= '0;
          r_cnt  <= '0;
          k_cnt  <= '0;
          c_cnt  <= '0;
          op     <= OP_FULL;
        end
        PREP: begin
          if (q_cnt == cfg_qcols - 1'b1) begin
            q_cnt  <= '0;
            qs_acc <= '0;
          end else begin
            q_cnt  <= q_cnt + 1'b1;
            qs_acc <= qs_acc + $signed(SW'(cfg_stride));
          end
          if (m_cnt == MW'(LANES - 1)) state <= ISSUE;
          else m_cnt <= m_cnt + 1'b1;
        end
        ISSUE: if (accept) begin
          case (op)
            OP_FULL, OP_ROW: op <= OP_MAC;
            OP_SHIFT:        op <= OP_ROW;
            default: begin
              if (!last_s) begin
                s_cnt <= s_cnt + 1'b1;
                s_off <= s_off + $signed(SW'(cfg_dil));
                op    <= OP_SHIFT;
              end else begin
                s_cnt <= '0;
                s_off <= '0;
                op    <= OP_FULL;
                c_cnt <= last_c ? '0 : c_cnt + 1'b1;
                if (last_c) begin
                  k_cnt <= last_k ? '0 : k_cnt + 1'b1;
                  if (last_k) begin
                    r_cnt <= last_r ? '0 : r_cnt + 1'b1;
                    if (last_r) begin
                      state  <= IDLE;
                      done_q <= 1'b1;
                    end
                  end
                end
              end
            end
          endcase
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conv_tap_sequencer_sva.sv
module conv_tap_sequencer_sva #(
  parameter int LANES = 8,
  parameter int FW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [FW-1:0]    cmd_s,
  input logic [LANES-1:0] cmd_mask,
  input logic             done
);
  a_r1_no_cmd_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_s) && $stable(cmd_mask));
  a_r4_full_then_compute: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'd0 |=> cmd_valid && cmd_op == 2'd3);
  a_r4_full_only_at_tap0: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd0 |-> cmd_s == '0);
  a_r5_shift_then_row: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'd1 |=> cmd_valid && cmd_op == 2'd2);
  a_r5_shift_not_at_tap0: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd1 |-> cmd_s != '0);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind conv_tap_sequencer conv_tap_sequencer_sva #(.LANES(LANES), .FW(FW)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_s(cmd_s), .cmd_mask(cmd_mask), .done(done));

// File: tb/conv_tap_sequencer_test.sv
`timescale 1ns/1ps
module conv_tap_sequencer_test;
  localparam int LANES = 8, CW = 8, FW = 4, BW = 4;
  localparam int IW = 2 + 2*FW + 2*BW + LANES;

  logic clk = 0, rst_n = 0, start = 0;
  logic [CW-1:0] cfg_width, cfg_qcols, cfg_q0;
  logic [FW-1:0] cfg_stride, cfg_pad, cfg_dil, cfg_taps, cfg_rtaps;
  logic [BW-1:0] cfg_kblk, cfg_cblk;
  logic busy, cmd_valid, cmd_ready, done;
  logic [1:0] cmd_op;
  logic [FW-1:0] cmd_s, cmd_r;
  logic [BW-1:0] cmd_k, cmd_c;
  logic [LANES-1:0] cmd_mask;

  int errors = 0, checks = 0, done_cnt = 0;
  logic [IW-1:0] exp_q[$];
  logic rnd_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign cmd_ready = rnd_ready ? lfsr[0] : 1'b1;

  conv_tap_sequencer #(.LANES(LANES), .CW(CW), .FW(FW), .BW(BW)) uut (.*);

  task automatic check(input bit ok, input string req, input logic [IW-1:0] act, input logic [IW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LANES-1:0] exp_mask(input int s);
    logic [LANES-1:0] mk;
    for (int m = 0; m < LANES; m++) begin
      int q = (int'(cfg_q0) + m) % int'(cfg_qcols);
      int w = q * int'(cfg_stride) - int'(cfg_pad) + s * int'(cfg_dil);
      mk[m] = (w < 0) || (w >= int'(cfg_width));
    end
    return mk;
  endfunction

  function automatic logic [IW-1:0] item(input int op, input int s, input int r, input int k, input int c);
    return {2'(op), FW'(s), FW'(r), BW'(k), BW'(c), exp_mask(s)};
  endfunction

  logic stalled = 0;
  logic [IW-1:0] held;
  always @(negedge clk) begin
    logic [IW-1:0] act;
    act = {cmd_op, cmd_s, cmd_r, cmd_k, cmd_c, cmd_mask};
    if (rst_n) begin
      if (stalled) check(cmd_valid && act == held, "R7 stall hold", act, held);
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) check(0, "R6 unexpected command", act, '0);
        else begin
          logic [IW-1:0] e;
          e = exp_q.pop_front();
          check(act == e, "R2/R3/R4/R5/R6 command", act, e);
        end
      end
      stalled = cmd_valid && !cmd_ready;
      held = act;
      if (done) begin
        done_cnt++;
        check(exp_q.size() == 0 && !busy, "R8 done after last compute", IW'(exp_q.size()), '0);
      end
    end
  end

  task automatic run_case(input int width, input int qcols, input int q0, input int stride,
                          input int pad, input int dil, input int taps, input int rt,
                          input int kb, input int cb, input bit rnd, input bit restart);
    cfg_width = CW'(width); cfg_qcols = CW'(qcols); cfg_q0 = CW'(q0);
    cfg_stride = FW'(stride); cfg_pad = FW'(pad); cfg_dil = FW'(dil);
    cfg_taps = FW'(taps); cfg_rtaps = FW'(rt); cfg_kblk = BW'(kb); cfg_cblk = BW'(cb);
    rnd_ready = rnd;
    done_cnt = 0;
    for (int r = 0; r < rt; r++)
      for (int k = 0; k < kb; k++)
        for (int c = 0; c < cb; c++)
          for (int s = 0; s < taps; s++) begin
            if (s == 0) exp_q.push_back(item(0, s, r, k, c));
            else begin
              exp_q.push_back(item(1, s, r, k, c));
              exp_q.push_back(item(2, s, r, k, c));
            end
            exp_q.push_back(item(3, s, r, k, c));
          end
    @(negedge clk) start = 1;
    @(posedge clk) #1 start = 0;
    for (int i = 0; i < LANES; i++) begin
      @(negedge clk);
      check(!cmd_valid, "R10 no command during lane prep", IW'(cmd_valid), '0);
    end
    @(negedge clk);
    check(cmd_valid, "R10 first command latency", IW'(cmd_valid), IW'(1));
    if (restart) begin
      start = 1;
      @(negedge clk) start = 0;
    end
    for (int t = 0; t < 5000 && done_cnt == 0; t++) @(negedge clk);
    repeat (LANES + 3) @(negedge clk);
    check(done_cnt == 1, "R8 R9 single done per run", IW'(done_cnt), IW'(1));
    check(!busy && !cmd_valid, "R9 idle after run", IW'({busy, cmd_valid}), '0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
      begin
        repeat (3) @(negedge clk);
        check(!busy && !cmd_valid && !done, "R1 reset state", IW'({busy, cmd_valid, done}), '0);
        rst_n = 1;
        @(negedge clk);
        run_case(9, 9, 5, 1, 1, 1, 3, 1, 1, 1, 0, 0);
        run_case(12, 6, 3, 2, 2, 2, 4, 2, 2, 2, 1, 0);
        run_case(9, 9, 0, 1, 1, 1, 1, 1, 3, 1, 1, 1);
        run_case(4, 8, 0, 1, 15, 1, 2, 1, 1, 2, 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule